// File: doc/BRIEF.md
# Two-Channel Packet DMA Register File

This block is the software-visible control surface of a storage controller with two packet DMA channels. A simple byte-addressed bus, with separate one-cycle write and read strobes, reaches one global key register and a register window for each channel. Each window holds a control word, a sticky status byte, a packet count, a packet pointer, a lookup word and two FIFO thresholds. The configuration values are driven straight out to the packet engines.

The control word also issues commands. One bit holds the channel engine in reset for as long as it stays set. Another bit requests a packet start. That request becomes a single-cycle start pulse, and only when the global key register holds the unlock value. The engines report errors and completions as single-cycle events. These collect in the status byte, which clears when it is read and which drives a maskable per-channel interrupt.

Reads return data one cycle after the read strobe. Unmapped addresses read as zero and ignore writes.

Top module: `dmarf_top`

## Requirements
- R1: Channel n's window starts at byte address 0x80 + n*0x20. Within a window the control word sits at 0x00, status at 0x02, packet count at 0x04, packet pointer at 0x0C, lookup at 0x10, input FIFO threshold at 0x14 and output FIFO threshold at 0x16. The count and both thresholds keep the low 16 bits of a write. The pointer and lookup keep all 32 bits. Each reads back what was written, on `bus_rdata` in the cycle after the read strobe.
- R2: After reset every register, `bus_rdata`, `eng_go`, `eng_reset`, `chan_irq` and `pio_mode` are zero.
- R3: The global key register at 0xC7 stores the low 8 bits of a write and reads back. A start request is honoured only while it holds 7.
- R4: Writing a control word with bit 7 set, while the key is 7 and bit 5 of the same write is clear, raises that channel's `eng_go` for exactly the one cycle after the write. Control bit 7 always reads back as 0, and every other control bit reads back as written.
- R5: While control bit 5 is set, the channel's `eng_reset` is high, its status stays zero and its engine events are dropped. A write that sets bit 5 produces no start pulse.
- R6: `pio_mode` for channel n equals bits 1:0 of that channel's control word.
- R7: Status bit 6 records a packet-state error, bit 4 an unexpected interrupt, bit 1 a packet completion and bit 0 a parity error. The bits are sticky. A status read returns them and clears them. Writes to the status address have no effect.
- R8: An event that arrives in the same cycle as a status read is absent from that read's data, but it is kept for the next read.
- R9: `chan_irq` for a channel is high when its status is nonzero and control bit 8 is clear. Setting bit 8 masks the interrupt and leaves the status intact.
- R10: Reads of unmapped addresses return 0, and writes to them change no register. The window offsets 0x06 and 0x1F and the addresses 0xC0 and above, other than 0xC7, are unmapped.
- R11: The channels are independent. A write, an event or a start on one channel leaves the other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| evt_perr | input | 2 | Per-channel parity error event |
| evt_psd | input | 2 | Per-channel packet-state error event |
| evt_uirq | input | 2 | Per-channel unexpected interrupt event |
| evt_done | input | 2 | Per-channel packet completion event |
| eng_reset | output | 2 | Per-channel engine reset level |
| eng_go | output | 2 | Per-channel single-cycle packet start |
| chan_irq | output | 2 | Per-channel interrupt |
| pio_mode | output | 4 | Per-channel PIO mode, 2 bits each, channel 0 in the low bits |
| pkt_count | output | 32 | Per-channel packet count, 16 bits each |
| pkt_ptr | output | 64 | Per-channel packet pointer, 32 bits each |
| lookup_val | output | 64 | Per-channel lookup word, 32 bits each |
| fifo_in_thr | output | 32 | Per-channel input FIFO threshold, 16 bits each |
| fifo_out_thr | output | 32 | Per-channel output FIFO threshold, 16 bits each |

## Verification
A decode error here lands a write in the wrong register. It shows up on the very next read-back of that address, or of the other channel's copy of it, and the configuration buses show it one cycle after the write. A wrong status state shows up on `chan_irq` in the cycle after the event, and on the next status read as missing, stale or uncleared bits. A wrong start qualification shows up on `eng_go` in the single cycle after the control write: a missing pulse, a pulse without the key, or a pulse that lasts more than one cycle.

// File: rtl/dmarf_pkg.sv
`timescale 1ns/1ps
package dmarf_pkg;

    localparam int DATA_W   = 32;
    localparam int STAT_W   = 8;

    // Offsets inside one channel window
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h02;
    localparam int OFS_CNT  = 'h04;
    localparam int OFS_PTR  = 'h0C;
    localparam int OFS_LKUP = 'h10;
    localparam int OFS_FIN  = 'h14;
    localparam int OFS_FOUT = 'h16;

    // Control word bit positions
    localparam int CTL_MASK = 8;
    localparam int CTL_GO   = 7;
    localparam int CTL_RST  = 5;

    // Status bit positions
    localparam int ST_PSD   = 6;
    localparam int ST_UIRQ  = 4;
    localparam int ST_DONE  = 1;
    localparam int ST_PERR  = 0;

    typedef struct packed {
        logic [15:0]       ctrl;
        logic [STAT_W-1:0] stat;
        logic [15:0]       cnt;
        logic [31:0]       ptr;
        logic [31:0]       lkup;
        logic [15:0]       fin;
        logic [15:0]       fout;
        logic              go;
    } chan_regs_t;

endpackage

// File: rtl/dmarf_lock.sv
`timescale 1ns/1ps
module dmarf_lock #(
    parameter logic [7:0] KEY = 8'd7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] lock_val,
    output logic       lock_ok
);
    logic [7:0] lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (hit && wr) lock_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign lock_val = lock_q;
    assign lock_ok  = (lock_q == KEY);

    // The key only moves on a write that hits it
    assert_key_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && wr) |=> $stable(lock_q));

endmodule

// File: rtl/dmarf_chan.sv
`timescale 1ns/1ps
module dmarf_chan
    import dmarf_pkg::*;
#(
    parameter int OFS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [OFS_W-1:0]  offs,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock_ok,
    input  logic              ev_perr,
    input  logic              ev_psd,
    input  logic              ev_uirq,
    input  logic              ev_done,
    output logic [DATA_W-1:0] rdata,
    output logic              eng_reset,
    output logic              eng_go,
    output logic              irq,
    output logic [1:0]        pio_mode,
    output logic [15:0]       cnt,
    output logic [31:0]       ptr,
    output logic [31:0]       lkup,
    output logic [15:0]       fin,
    output logic [15:0]       fout
);
    chan_regs_t regs_d, regs_q;
    logic [STAT_W-1:0] ev_bits;
    logic wr_hit, rd_stat;

    always_comb begin
        ev_bits = '0;
        ev_bits[ST_PSD]  = ev_psd;
        ev_bits[ST_UIRQ] = ev_uirq;
        ev_bits[ST_DONE] = ev_done;
        ev_bits[ST_PERR] = ev_perr;
    end

    assign wr_hit  = sel && wr;
    assign rd_stat = sel && rd && (offs == OFS_W'(OFS_STAT));

    always_comb begin
        regs_d    = regs_q;
        regs_d.go = 1'b0;
        if (wr_hit) begin
            case (offs)
                OFS_W'(OFS_CTRL): begin
                    regs_d.ctrl         = wdata[15:0];
                    regs_d.ctrl[CTL_GO] = 1'b0;
                    regs_d.go = wdata[CTL_GO] && !wdata[CTL_RST] && lock_ok;
                end
                OFS_W'(OFS_CNT):  regs_d.cnt  = wdata[15:0];
                OFS_W'(OFS_PTR):  regs_d.ptr  = wdata;
                OFS_W'(OFS_LKUP): regs_d.lkup = wdata;
                OFS_W'(OFS_FIN):  regs_d.fin  = wdata[15:0];
                OFS_W'(OFS_FOUT): regs_d.fout = wdata[15:0];
                default: ;
            endcase
        end
        if (rd_stat) regs_d.stat = '0;
        regs_d.stat = regs_d.stat | ev_bits;
        if (regs_d.ctrl[CTL_RST]) regs_d.stat = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (offs)
                OFS_W'(OFS_CTRL): rdata = {16'b0, regs_q.ctrl};
                OFS_W'(OFS_STAT): rdata = {{(DATA_W-STAT_W){1'b0}}, regs_q.stat};
                OFS_W'(OFS_CNT):  rdata = {16'b0, regs_q.cnt};
                OFS_W'(OFS_PTR):  rdata = regs_q.ptr;
                OFS_W'(OFS_LKUP): rdata = regs_q.lkup;
                OFS_W'(OFS_FIN):  rdata = {16'b0, regs_q.fin};
                OFS_W'(OFS_FOUT): rdata = {16'b0, regs_q.fout};
                default:          rdata = '0;
            endcase
        end
    end

    assign eng_reset = regs_q.ctrl[CTL_RST];
    assign eng_go    = regs_q.go;
    assign irq       = (|regs_q.stat) && !regs_q.ctrl[CTL_MASK];
    assign pio_mode  = regs_q.ctrl[1:0];
    assign cnt       = regs_q.cnt;
    assign ptr       = regs_q.ptr;
    assign lkup      = regs_q.lkup;
    assign fin       = regs_q.fin;
    assign fout      = regs_q.fout;

    // A start pulse needs the key from the neighbouring lock block
    assert_go_keyed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> $past(lock_ok));

    // A start is never issued together with an engine reset
    assert_go_outside_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> !eng_reset);

    // Held in reset means no pending interrupt
    assert_reset_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> !irq);

    // A status read with no new event leaves nothing to interrupt on
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && ev_bits == '0) |=> !irq);

    // A set mask keeps the interrupt low
    assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctrl[CTL_MASK] |-> !irq);

    // An event on an unmasked channel outside reset raises the interrupt
    assert_event_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_bits != '0) && !regs_d.ctrl[CTL_RST] && !regs_d.ctrl[CTL_MASK]) |=> irq);

endmodule

// File: rtl/dmarf_rdmux.sv
`timescale 1ns/1ps
module dmarf_rdmux
    import dmarf_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd,
    input  logic [NUM_CH-1:0]        chan_hit,
    input  logic [NUM_CH*DATA_W-1:0] chan_rd,
    input  logic                     lock_hit,
    input  logic [7:0]               lock_val,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (rd) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (chan_hit[n]) rdata_d = rdata_d | chan_rd[n*DATA_W +: DATA_W];
            end
            if (lock_hit) rdata_d = rdata_d | {{(DATA_W-8){1'b0}}, lock_val};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // An access that hits nothing returns zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !lock_hit && chan_hit == '0) |=> (rdata == '0));

    // At most one target is selected
    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chan_hit, lock_hit}));

endmodule

// File: rtl/dmarf_top.sv
`timescale 1ns/1ps
module dmarf_top
    import dmarf_pkg::*;
#(
    parameter int          NUM_CH    = 2,
    parameter int          ADDR_W    = 8,
    parameter int          WIN_SIZE  = 32,
    parameter logic [7:0]  WIN_BASE  = 8'h80,
    parameter logic [7:0]  LOCK_ADDR = 8'hC7,
    parameter logic [7:0]  LOCK_KEY  = 8'd7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_CH-1:0]        evt_perr,
    input  logic [NUM_CH-1:0]        evt_psd,
    input  logic [NUM_CH-1:0]        evt_uirq,
    input  logic [NUM_CH-1:0]        evt_done,
    output logic [NUM_CH-1:0]        eng_reset,
    output logic [NUM_CH-1:0]        eng_go,
    output logic [NUM_CH-1:0]        chan_irq,
    output logic [2*NUM_CH-1:0]      pio_mode,
    output logic [16*NUM_CH-1:0]     pkt_count,
    output logic [32*NUM_CH-1:0]     pkt_ptr,
    output logic [32*NUM_CH-1:0]     lookup_val,
    output logic [16*NUM_CH-1:0]     fifo_in_thr,
    output logic [16*NUM_CH-1:0]     fifo_out_thr
);
    localparam int WIN_W  = $clog2(WIN_SIZE);
    localparam int IDX_W  = ADDR_W - WIN_W;
    localparam int WIN_HI = int'(WIN_BASE) + NUM_CH * WIN_SIZE;

    logic [ADDR_W-1:0]        addr_rel;
    logic                     win_hit;
    logic                     lock_hit;
    logic [NUM_CH-1:0]        chan_hit;
    logic [NUM_CH*DATA_W-1:0] chan_rd;
    logic [7:0]               lock_val;
    logic                     lock_ok;

    assign addr_rel = bus_addr - ADDR_W'(WIN_BASE);
    assign win_hit  = (int'(bus_addr) >= int'(WIN_BASE)) && (int'(bus_addr) < WIN_HI);
    assign lock_hit = (bus_addr == ADDR_W'(LOCK_ADDR));

    dmarf_lock #(.KEY(LOCK_KEY)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (lock_hit),
        .wr       (bus_wr),
        .wdata    (bus_wdata[7:0]),
        .lock_val (lock_val),
        .lock_ok  (lock_ok)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        assign chan_hit[n] = win_hit && (addr_rel[ADDR_W-1:WIN_W] == IDX_W'(n));

        dmarf_chan #(.OFS_W(WIN_W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (chan_hit[n]),
            .wr        (bus_wr),
            .rd        (bus_rd),
            .offs      (addr_rel[WIN_W-1:0]),
            .wdata     (bus_wdata),
            .lock_ok   (lock_ok),
            .ev_perr   (evt_perr[n]),
            .ev_psd    (evt_psd[n]),
            .ev_uirq   (evt_uirq[n]),
            .ev_done   (evt_done[n]),
            .rdata     (chan_rd[n*DATA_W +: DATA_W]),
            .eng_reset (eng_reset[n]),
            .eng_go    (eng_go[n]),
            .irq       (chan_irq[n]),
            .pio_mode  (pio_mode[2*n +: 2]),
            .cnt       (pkt_count[16*n +: 16]),
            .ptr       (pkt_ptr[32*n +: 32]),
            .lkup      (lookup_val[32*n +: 32]),
            .fin       (fifo_in_thr[16*n +: 16]),
            .fout      (fifo_out_thr[16*n +: 16])
        );
    end

    dmarf_rdmux #(.NUM_CH(NUM_CH)) rdmux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .chan_hit (chan_hit),
        .chan_rd  (chan_rd),
        .lock_hit (lock_hit),
        .lock_val (lock_val),
        .rdata    (bus_rdata)
    );

    // Start pulses never coincide on one write
    assert_single_go_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_go));

endmodule

// File: tb/dmarf_top_tb.sv
`timescale 1ns/1ps
module dmarf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  evt_perr = '0, evt_psd = '0, evt_uirq = '0, evt_done = '0;
    logic [1:0]  eng_reset, eng_go, chan_irq;
    logic [3:0]  pio_mode;
    logic [31:0] pkt_count, fifo_in_thr, fifo_out_thr;
    logic [63:0] pkt_ptr, lookup_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dmarf_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_perr(evt_perr), .evt_psd(evt_psd), .evt_uirq(evt_uirq), .evt_done(evt_done),
        .eng_reset(eng_reset), .eng_go(eng_go), .chan_irq(chan_irq), .pio_mode(pio_mode),
        .pkt_count(pkt_count), .pkt_ptr(pkt_ptr), .lookup_val(lookup_val),
        .fifo_in_thr(fifo_in_thr), .fifo_out_thr(fifo_out_thr)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] val;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'h80, 32'h0000_0103, 8'd1},  // R1 ctrl ch0: mask + mode 3
        '{1'b1, 8'h80, 32'h0000_0103, 8'd1},
        '{1'b0, 8'h84, 32'h0000_0001, 8'd1},  // R1 count
        '{1'b1, 8'h84, 32'h0000_0001, 8'd1},
        '{1'b0, 8'h8C, 32'hDEAD_BEE8, 8'd1},  // R1 pointer
        '{1'b1, 8'h8C, 32'hDEAD_BEE8, 8'd1},
        '{1'b0, 8'h90, 32'h1234_5678, 8'd1},  // R1 lookup
        '{1'b1, 8'h90, 32'h1234_5678, 8'd1},
        '{1'b0, 8'h94, 32'h0000_0100, 8'd1},  // R1 in threshold
        '{1'b1, 8'h94, 32'h0000_0100, 8'd1},
        '{1'b0, 8'h96, 32'h0000_0200, 8'd1},  // R1 out threshold
        '{1'b1, 8'h96, 32'h0000_0200, 8'd1},
        '{1'b0, 8'hA4, 32'hABCD_1234, 8'd1},  // R1 ch1 count keeps 16 bits
        '{1'b1, 8'hA4, 32'h0000_1234, 8'd1},
        '{1'b1, 8'h84, 32'h0000_0001, 8'd11}, // R11 ch0 count untouched
        '{1'b1, 8'hAC, 32'h0000_0000, 8'd11}, // R11 ch1 pointer untouched
        '{1'b0, 8'hC7, 32'h0000_0005, 8'd3},  // R3 key register
        '{1'b1, 8'hC7, 32'h0000_0005, 8'd3},
        '{1'b0, 8'h86, 32'h0000_0055, 8'd10}, // R10 unmapped offset
        '{1'b1, 8'h86, 32'h0000_0000, 8'd10},
        '{1'b0, 8'hC0, 32'h0000_0077, 8'd10}, // R10 unmapped global
        '{1'b1, 8'hC0, 32'h0000_0000, 8'd10}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int ch, input logic perr, input logic psd,
                         input logic uirq, input logic dn);
        evt_perr[ch] = perr; evt_psd[ch] = psd; evt_uirq[ch] = uirq; evt_done[ch] = dn;
        @(negedge clk);
        evt_perr = '0; evt_psd = '0; evt_uirq = '0; evt_done = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R2 act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        chk("R2 rdata", 64'(bus_rdata), 64'h0);
        chk("R2 irq", 64'(chan_irq), 64'h0);
        chk("R2 go", 64'(eng_go), 64'h0);
        chk("R2 eng_reset", 64'(eng_reset), 64'h0);
        chk("R2 pio", 64'(pio_mode), 64'h0);
        bus_read(8'hA0, got);
        chk("R2 ctrl ch1", 64'(got), 64'h0);
        bus_read(8'h82, got);
        chk("R2 status ch0", 64'(got), 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].rd) begin
                bus_read(VEC[i].addr, got);
                chk($sformatf("R%0d vec%0d", VEC[i].req, i), 64'(got), 64'(VEC[i].val));
            end else begin
                bus_write(VEC[i].addr, VEC[i].val);
            end
        end

        // R6 mode output and R1 config buses
        chk("R6 pio ch0", 64'(pio_mode[1:0]), 64'h3);
        chk("R1 ptr bus", pkt_ptr[31:0], 64'hDEAD_BEE8);
        chk("R1 thr bus", 64'(fifo_out_thr[15:0]), 64'h200);

        // R3 no start without the key (key holds 5)
        bus_write(8'h80, 32'h0000_0083);
        chk("R3 go locked", 64'(eng_go), 64'h0);
        bus_read(8'h80, got);
        chk("R4 go bit reads 0", 64'(got), 64'h0003);

        // R4 keyed start pulse
        bus_write(8'hC7, 32'h7);
        bus_write(8'h80, 32'h0000_0083);
        chk("R4 go pulse", 64'(eng_go), 64'h1);
        @(negedge clk);
        chk("R4 go one cycle", 64'(eng_go), 64'h0);

        // R11 start on ch1 only
        bus_write(8'hA0, 32'h0000_0080);
        chk("R11 go ch1", 64'(eng_go), 64'h2);

        // R5 reset hold
        bus_write(8'h80, 32'h0000_00A3);
        chk("R5 no go in reset", 64'(eng_go), 64'h0);
        chk("R5 reset level", 64'(eng_reset), 64'h1);
        pulse(0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 event dropped irq", 64'(chan_irq), 64'h0);
        bus_write(8'h80, 32'h0000_0003);
        chk("R5 reset released", 64'(eng_reset), 64'h0);
        bus_read(8'h82, got);
        chk("R5 status empty", 64'(got), 64'h0);

        // R9 irq on event, other channel quiet
        pulse(0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 irq ch0", 64'(chan_irq), 64'h1);
        // R7 bit positions and clear-on-read
        pulse(0, 1'b0, 1'b1, 1'b1, 1'b1);
        bus_read(8'h82, got);
        chk("R7 status bits", 64'(got), 64'h53);
        chk("R7 irq after read", 64'(chan_irq), 64'h0);
        bus_read(8'h82, got);
        chk("R7 cleared", 64'(got), 64'h0);

        // R9 mask keeps status
        bus_write(8'h80, 32'h0000_0103);
        pulse(0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R9 masked irq", 64'(chan_irq), 64'h0);
        bus_read(8'h82, got);
        chk("R9 status kept", 64'(got), 64'h10);

        // R8 event during read
        bus_rd = 1'b1; bus_addr = 8'hA2; evt_done[1] = 1'b1;
        @(negedge clk);
        got = bus_rdata;
        bus_rd = 1'b0; evt_done = '0;
        chk("R8 read excludes event", 64'(got), 64'h0);
        chk("R8 irq ch1", 64'(chan_irq), 64'h2);
        bus_read(8'hA2, got);
        chk("R8 event kept", 64'(got), 64'h2);

        // R7 status write ignored
        pulse(1, 1'b1, 1'b0, 1'b0, 1'b0);
        bus_write(8'hA2, 32'h0);
        bus_read(8'hA2, got);
        chk("R7 status write ignored", 64'(got), 64'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule